// File: doc/BRIEF.md
# Indirect Register Access Port

This block is the slave-side register front end of a network controller. Each access comes in over a 32-byte I/O window and is sorted into one of five resources: a 16-byte station-address area, a shared pointer port, a port for MAC control/status data, a port for bus-configuration data, and a reset port. A single pointer register picks the entry in both 128 x 16-bit register banks. The two data ports then read or write that entry in their own bank. The answer comes back one clock after the access. It raises select together with either ready or retry, and it carries read data and an illegal-write flag.

Reading the reset port starts an internal soft reset. The soft reset clears the pointer and the MAC bank and runs for a parameterised number of cycles, shown on `srst_busy`. Any access made in that time is answered with retry and has no effect. The block comes out of hard reset in 16-bit (Word) mode. A 32-bit write to the control/status data port moves it to 32-bit (DWord) mode, and it stays there until the next hard reset. In DWord mode the ports sit at 4-byte-aligned offsets.

The control process holds two enumerated state variables. The soft-reset machine has the states SR_IDLE and SR_BUSY. It takes SR_IDLE -> SR_BUSY on a legal read of the reset port, and SR_BUSY -> SR_IDLE when its down-counter reaches zero. The width machine has the states MD_WORD and MD_DWORD. It takes MD_WORD -> MD_DWORD on the legal 32-bit data-port write, and it has no way back except hard reset.

Top module: `regport_front`

## Requirements
- R1: Word-mode offsets: 0x00-0x0F station area (byte N at offset N, a word write at offset A stores wdata[7:0] at A and wdata[15:8] at A+1), 0x10 MAC data port, 0x12 pointer, 0x14 reset port, 0x16 configuration data port. Register data uses bits [15:0], the pointer bits [6:0], and upper read bits are zero.
- R2: The pointer keeps its value until the next legal pointer write or a reset. Writes to the data ports, including setting the stop bit (bit 2) of MAC entry 0, leave it unchanged.
- R3: The MAC data port reads and writes the MAC bank entry selected by the pointer. The configuration data port reads and writes the configuration bank entry selected by the same pointer. The two banks are separate.
- R4: A legal read of the reset port returns 0 and starts a soft reset. The soft reset clears the pointer and every MAC bank entry, keeps the configuration bank, the station area and the mode, and holds `srst_busy` high for SRST_CYCLES cycles.
- R5: While `srst_busy` is high, every access is answered with rsp_sel=1, rsp_retry=1, rsp_ack=0 and has no effect.
- R6: A write to the reset port is acknowledged and has no effect: it does not start a soft reset and does not change the pointer.
- R7: After hard reset the block is in Word mode, and bit 7 of configuration entry 18 reads 0. It reads 1 in DWord mode. Only hard reset returns the block to Word mode, and hard reset also clears both banks and the station area.
- R8: In Word mode a 32-bit write (size code 2) to offset 0x10 is legal. It writes wdata[15:0] to the selected MAC entry and switches the block to DWord mode.
- R9: In Word mode only 16-bit accesses (size code 1) at even offsets are legal, plus byte reads (size code 0) in the station area. Illegal reads return 0 without error. Illegal writes set rsp_err and change nothing.
- R10: In DWord mode only 32-bit accesses at 4-byte-aligned offsets are legal. The station area stays at 0x00-0x0F, and the ports sit at 0x10 MAC data, 0x14 pointer, 0x18 reset and 0x1C configuration data.
- R11: An access in cycle N is answered in cycle N+1 for one cycle only, with rsp_sel=1 and exactly one of rsp_ack or rsp_retry. After hard reset all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 5 | Byte offset in the I/O window |
| acc_size | input | 2 | 0 byte, 1 word, 2 dword |
| acc_wdata | input | 32 | Write data |
| rsp_sel | output | 1 | Device selected for the previous access |
| rsp_ack | output | 1 | Access completed |
| rsp_retry | output | 1 | Access refused, retry later |
| rsp_err | output | 1 | Illegal write dropped |
| rsp_rdata | output | 32 | Read data |
| srst_busy | output | 1 | Soft reset in progress |

## Verification
The assertions assume that `acc_valid` is a single-cycle strobe and that address, size and write data are stable in the cycle it is high. They also assume `acc_size` never carries code 3. The bench meets these conditions by driving each access for one cycle, setting all inputs on the falling edge, using only the three defined size codes, and leaving an idle cycle between accesses. The retry property depends on `srst_busy` changing only at clock edges. For that reason the bench makes its during-busy access in the cycle right after the reset-port read, and it waits on the busy output before going on.

// File: rtl/regport_pkg.sv
package regport_pkg;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_STA,
        TGT_MAC,
        TGT_PTR,
        TGT_RST,
        TGT_CFG
    } tgt_e;

    typedef enum logic {SR_IDLE, SR_BUSY} srst_state_e;
    typedef enum logic {MD_WORD, MD_DWORD} mode_e;

    localparam logic [1:0] SZ_BYTE  = 2'd0;
    localparam logic [1:0] SZ_WORD  = 2'd1;
    localparam logic [1:0] SZ_DWORD = 2'd2;

    // configuration entry and bit that mirror the access width
    localparam int MODE_ENTRY = 18;
    localparam int MODE_BIT   = 7;

endpackage

// File: rtl/regport_decode.sv
module regport_decode
    import regport_pkg::*;
(
    input  logic [4:0] addr,
    input  logic [1:0] size,
    input  logic       write,
    input  logic       dword_mode,
    output tgt_e       tgt,
    output logic       legal,
    output logic       go_dword
);

    always_comb begin
        tgt      = TGT_NONE;
        legal    = 1'b0;
        go_dword = 1'b0;
        if (!dword_mode) begin
            if (!addr[4]) begin
                tgt   = TGT_STA;
                legal = (size == SZ_WORD && !addr[0]) || (size == SZ_BYTE && !write);
            end else begin
                unique case (addr)
                    5'h10:   tgt = TGT_MAC;
                    5'h12:   tgt = TGT_PTR;
                    5'h14:   tgt = TGT_RST;
                    5'h16:   tgt = TGT_CFG;
                    default: tgt = TGT_NONE;
                endcase
                legal = (size == SZ_WORD);
                if (tgt == TGT_MAC && size == SZ_DWORD && write) begin
                    legal    = 1'b1;
                    go_dword = 1'b1;
                end
            end
        end else begin
            legal = (size == SZ_DWORD) && (addr[1:0] == 2'b00);
            if (!addr[4]) begin
                tgt = TGT_STA;
            end else begin
                unique case (addr)
                    5'h10:   tgt = TGT_MAC;
                    5'h14:   tgt = TGT_PTR;
                    5'h18:   tgt = TGT_RST;
                    5'h1C:   tgt = TGT_CFG;
                    default: tgt = TGT_NONE;
                endcase
            end
        end
        if (tgt == TGT_NONE) begin
            legal    = 1'b0;
            go_dword = 1'b0;
        end
    end

endmodule

// File: rtl/regport_bank.sv
module regport_bank #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             we,
    input  logic [AW-1:0]    idx,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (clr) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/regport_station.sv
module regport_station #(
    parameter int NBYTES = 16,
    localparam int AW    = $clog2(NBYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          wide,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata
);

    logic [7:0]    mem [NBYTES];
    logic [AW-1:0] ix [4];

    generate
        for (genvar k = 0; k < 4; k++) begin : g_lane
            assign ix[k] = addr + AW'(k);
            assign rdata[8*k +: 8] = mem[ix[k]];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTES; i++) mem[i] <= '0;
        end else if (we) begin
            mem[ix[0]] <= wdata[7:0];
            mem[ix[1]] <= wdata[15:8];
            if (wide) begin
                mem[ix[2]] <= wdata[23:16];
                mem[ix[3]] <= wdata[31:24];
            end
        end
    end

endmodule

// File: rtl/regport_ctrl.sv
module regport_ctrl
    import regport_pkg::*;
#(
    parameter int PTR_W       = 7,
    parameter int SRST_CYCLES = 16,
    localparam int CNT_W      = $clog2(SRST_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_fire,
    input  tgt_e             acc_tgt,
    input  logic             acc_write,
    input  logic             go_dword,
    input  logic [PTR_W-1:0] ptr_wdata,
    output logic [PTR_W-1:0] ptr,
    output logic             dword_mode,
    output logic             busy,
    output logic             soft_go
);

    srst_state_e      sr_q, sr_d;
    mode_e            md_q, md_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic             go;

    always_comb begin
        go    = acc_fire && acc_tgt == TGT_RST && !acc_write;
        sr_d  = sr_q;
        cnt_d = cnt_q;
        unique case (sr_q)
            SR_IDLE: if (go) begin
                sr_d  = SR_BUSY;
                cnt_d = CNT_W'(SRST_CYCLES - 1);
            end
            SR_BUSY: if (cnt_q == '0) sr_d = SR_IDLE;
                     else cnt_d = cnt_q - 1'b1;
        endcase
        md_d = md_q;
        unique case (md_q)
            MD_WORD:  if (acc_fire && go_dword) md_d = MD_DWORD;
            MD_DWORD: md_d = MD_DWORD;
        endcase
        ptr_d = ptr_q;
        if (go) ptr_d = '0;
        else if (acc_fire && acc_tgt == TGT_PTR && acc_write) ptr_d = ptr_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= SR_IDLE;
            md_q  <= MD_WORD;
            cnt_q <= '0;
            ptr_q <= '0;
        end else begin
            sr_q  <= sr_d;
            md_q  <= md_d;
            cnt_q <= cnt_d;
            ptr_q <= ptr_d;
        end
    end

    always_comb begin
        busy       = (sr_q == SR_BUSY);
        dword_mode = (md_q == MD_DWORD);
        ptr        = ptr_q;
        soft_go    = go;
    end

    // R2: pointer moves only on a pointer write or a soft reset
    a_r2_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!go && !(acc_fire && acc_tgt == TGT_PTR && acc_write)) |=> $stable(ptr_q));
    // R4: soft reset leaves the pointer at zero and the machine busy
    a_r4_soft_clears: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (ptr_q == '0) && busy);
    // R7: DWord mode is sticky until hard reset
    a_r7_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        dword_mode |=> dword_mode);

endmodule

// File: rtl/regport_front.sv
module regport_front
    import regport_pkg::*;
#(
    parameter int REG_DEPTH   = 128,
    parameter int REG_WIDTH   = 16,
    parameter int STA_BYTES   = 16,
    parameter int SRST_CYCLES = 16,
    localparam int PTR_W      = $clog2(REG_DEPTH),
    localparam int STA_AW     = $clog2(STA_BYTES)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [4:0]  acc_addr,
    input  logic [1:0]  acc_size,
    input  logic [31:0] acc_wdata,
    output logic        rsp_sel,
    output logic        rsp_ack,
    output logic        rsp_retry,
    output logic        rsp_err,
    output logic [31:0] rsp_rdata,
    output logic        srst_busy
);

    tgt_e                 tgt;
    logic                 legal, go_dword, dword_mode, busy, soft_go, fire;
    logic [PTR_W-1:0]     ptr;
    logic [REG_WIDTH-1:0] mac_rd, cfg_rd, cfg_view;
    logic [31:0]          sta_rd, rd_mux;

    regport_decode u_dec (
        .addr(acc_addr), .size(acc_size), .write(acc_write),
        .dword_mode(dword_mode), .tgt(tgt), .legal(legal), .go_dword(go_dword)
    );

    assign fire = acc_valid && legal && !busy;

    regport_ctrl #(.PTR_W(PTR_W), .SRST_CYCLES(SRST_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .acc_fire(fire), .acc_tgt(tgt),
        .acc_write(acc_write), .go_dword(go_dword), .ptr_wdata(acc_wdata[PTR_W-1:0]),
        .ptr(ptr), .dword_mode(dword_mode), .busy(busy), .soft_go(soft_go)
    );

    regport_bank #(.DEPTH(REG_DEPTH), .WIDTH(REG_WIDTH)) u_mac (
        .clk(clk), .rst_n(rst_n), .clr(soft_go),
        .we(fire && acc_write && tgt == TGT_MAC),
        .idx(ptr), .wdata(acc_wdata[REG_WIDTH-1:0]), .rdata(mac_rd)
    );

    regport_bank #(.DEPTH(REG_DEPTH), .WIDTH(REG_WIDTH)) u_cfg (
        .clk(clk), .rst_n(rst_n), .clr(1'b0),
        .we(fire && acc_write && tgt == TGT_CFG),
        .idx(ptr), .wdata(acc_wdata[REG_WIDTH-1:0]), .rdata(cfg_rd)
    );

    regport_station #(.NBYTES(STA_BYTES)) u_sta (
        .clk(clk), .rst_n(rst_n),
        .we(fire && acc_write && tgt == TGT_STA),
        .wide(acc_size == SZ_DWORD),
        .addr(acc_addr[STA_AW-1:0]), .wdata(acc_wdata), .rdata(sta_rd)
    );

    always_comb begin
        cfg_view = cfg_rd;
        if (int'(ptr) == MODE_ENTRY) cfg_view[MODE_BIT] = dword_mode;
        unique case (tgt)
            TGT_STA: begin
                if (acc_size == SZ_BYTE)      rd_mux = {24'b0, sta_rd[7:0]};
                else if (acc_size == SZ_WORD) rd_mux = {16'b0, sta_rd[15:0]};
                else                          rd_mux = sta_rd;
            end
            TGT_MAC: rd_mux = 32'(mac_rd);
            TGT_PTR: rd_mux = 32'(ptr);
            TGT_CFG: rd_mux = 32'(cfg_view);
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_sel   <= 1'b0;
            rsp_ack   <= 1'b0;
            rsp_retry <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_sel   <= acc_valid;
            rsp_ack   <= acc_valid && !busy;
            rsp_retry <= acc_valid && busy;
            rsp_err   <= acc_valid && !busy && acc_write && !legal;
            rsp_rdata <= (fire && !acc_write) ? rd_mux : '0;
        end
    end

    assign srst_busy = busy;

    // R5: accesses during soft reset are refused
    a_r5_retry_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && srst_busy) |=> (rsp_sel && rsp_retry && !rsp_ack));
    // R11: never both completion and retry
    a_r11_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_ack && rsp_retry));
    // R11: every access is answered on the next cycle
    a_r11_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_sel && (rsp_ack || rsp_retry));

endmodule

// File: tb/regport_front_test.sv
module regport_front_test;

    localparam int SRST = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [4:0]  acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic        rsp_sel, rsp_ack, rsp_retry, rsp_err, srst_busy;
    logic [31:0] rsp_rdata;

    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    regport_front #(.SRST_CYCLES(SRST)) uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .rsp_sel(rsp_sel), .rsp_ack(rsp_ack), .rsp_retry(rsp_retry),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .srst_busy(srst_busy)
    );

    typedef struct packed {
        logic        wr;
        logic [4:0]  addr;
        logic [1:0]  size;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic        err;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 5'h12, 2'd1, 32'h0005,     32'h0,      1'b0, 4'd1},  // R1 pointer write
        '{1'b1, 5'h10, 2'd1, 32'h1234,     32'h0,      1'b0, 4'd3},  // R3 MAC write
        '{1'b0, 5'h10, 2'd1, 32'h0,        32'h1234,   1'b0, 4'd3},  // R3 MAC read
        '{1'b1, 5'h16, 2'd1, 32'hBEEF,     32'h0,      1'b0, 4'd3},  // R3 cfg write
        '{1'b0, 5'h16, 2'd1, 32'h0,        32'hBEEF,   1'b0, 4'd3},  // R3 cfg read
        '{1'b0, 5'h10, 2'd1, 32'h0,        32'h1234,   1'b0, 4'd3},  // R3 banks separate
        '{1'b0, 5'h12, 2'd1, 32'h0,        32'h0005,   1'b0, 4'd2},  // R2 pointer held
        '{1'b1, 5'h02, 2'd1, 32'hA1B2,     32'h0,      1'b0, 4'd1},  // R1 station word
        '{1'b0, 5'h03, 2'd0, 32'h0,        32'h00A1,   1'b0, 4'd9},  // R9 byte read
        '{1'b0, 5'h02, 2'd0, 32'h0,        32'h00B2,   1'b0, 4'd9},  // R9 byte read
        '{1'b0, 5'h02, 2'd1, 32'h0,        32'hA1B2,   1'b0, 4'd1},  // R1 station word
        '{1'b0, 5'h11, 2'd1, 32'h0,        32'h0,      1'b0, 4'd9},  // R9 misaligned read
        '{1'b1, 5'h13, 2'd1, 32'hFFFF,     32'h0,      1'b1, 4'd9},  // R9 misaligned write
        '{1'b0, 5'h18, 2'd1, 32'h0,        32'h0,      1'b0, 4'd9},  // R9 unmapped read
        '{1'b1, 5'h1A, 2'd1, 32'h1,        32'h0,      1'b1, 4'd9},  // R9 unmapped write
        '{1'b0, 5'h10, 2'd2, 32'h0,        32'h0,      1'b0, 4'd8},  // R8 32-bit read illegal
        '{1'b1, 5'h04, 2'd0, 32'h77,       32'h0,      1'b1, 4'd9},  // R9 byte write illegal
        '{1'b0, 5'h04, 2'd1, 32'h0,        32'h0,      1'b0, 4'd9},  // R9 nothing written
        '{1'b1, 5'h11, 2'd1, 32'hFFFF,     32'h0,      1'b1, 4'd9},  // R9 misaligned write
        '{1'b0, 5'h10, 2'd1, 32'h0,        32'h1234,   1'b0, 4'd9},  // R9 entry untouched
        '{1'b1, 5'h14, 2'd1, 32'h0,        32'h0,      1'b0, 4'd6},  // R6 reset-port write
        '{1'b0, 5'h12, 2'd1, 32'h0,        32'h0005,   1'b0, 4'd6}   // R6 pointer kept
    };

    task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [4:0] a, input logic [1:0] sz, input logic [31:0] wd);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_size = sz; acc_wdata = wd;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; acc_wdata = '0;
    endtask

    task automatic hard_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        hard_reset();
        // R11 reset state of the response outputs
        chk(11, "reset outputs", {27'b0, rsp_sel, rsp_ack, rsp_retry, rsp_err, srst_busy}, 32'h0);
        chk(11, "reset rdata", rsp_rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            acc(VEC[i].wr, VEC[i].addr, VEC[i].size, VEC[i].wdata);
            chk(int'(VEC[i].req), $sformatf("vec %0d ack", i), {30'b0, rsp_ack, rsp_retry}, 32'h2);
            chk(int'(VEC[i].req), $sformatf("vec %0d err", i), 32'(rsp_err), 32'(VEC[i].err));
            chk(int'(VEC[i].req), $sformatf("vec %0d rdata", i), rsp_rdata, VEC[i].exp);
        end
        chk(6, "no busy after reset-port write", 32'(srst_busy), 32'h0);
        @(negedge clk);
        chk(11, "sel lasts one cycle", {30'b0, rsp_sel, rsp_ack}, 32'h0);

        // R2 setting stop bit in MAC entry 0 leaves the pointer alone
        acc(1, 5'h12, 2'd1, 32'h0);
        acc(1, 5'h10, 2'd1, 32'h0004);
        acc(0, 5'h12, 2'd1, 32'h0);
        chk(2, "pointer after stop bit", rsp_rdata, 32'h0);

        // R7 mode flag reads 0 after hard reset
        acc(1, 5'h12, 2'd1, 32'd18);
        acc(0, 5'h16, 2'd1, 32'h0);
        chk(7, "mode flag word", rsp_rdata, 32'h0);

        // R4 / R5 soft reset from Word mode
        acc(1, 5'h12, 2'd1, 32'd5);
        acc(0, 5'h14, 2'd1, 32'h0);
        chk(4, "reset read ack", {30'b0, rsp_ack, rsp_retry}, 32'h2);
        chk(4, "reset read data", rsp_rdata, 32'h0);
        chk(4, "busy raised", 32'(srst_busy), 32'h1);
        acc(1, 5'h12, 2'd1, 32'd7);
        chk(5, "retry during busy", {29'b0, rsp_sel, rsp_ack, rsp_retry}, 32'h5);
        while (srst_busy) @(negedge clk);
        acc(0, 5'h12, 2'd1, 32'h0);
        chk(5, "pointer after busy write", rsp_rdata, 32'h0);
        acc(0, 5'h10, 2'd1, 32'h0);
        chk(4, "MAC entry 0 cleared", rsp_rdata, 32'h0);
        acc(1, 5'h12, 2'd1, 32'd5);
        acc(0, 5'h10, 2'd1, 32'h0);
        chk(4, "MAC entry 5 cleared", rsp_rdata, 32'h0);
        acc(0, 5'h16, 2'd1, 32'h0);
        chk(4, "cfg bank kept", rsp_rdata, 32'hBEEF);
        acc(0, 5'h02, 2'd1, 32'h0);
        chk(4, "station kept", rsp_rdata, 32'hA1B2);

        // R8 switch to DWord mode
        acc(1, 5'h12, 2'd1, 32'd18);
        acc(1, 5'h10, 2'd2, 32'h0000_0042);
        chk(8, "switch write ok", {30'b0, rsp_ack, rsp_err}, 32'h2);
        acc(0, 5'h1C, 2'd2, 32'h0);
        chk(7, "mode flag dword", rsp_rdata, 32'h0080);
        acc(0, 5'h10, 2'd2, 32'h0);
        chk(8, "switch wrote MAC entry", rsp_rdata, 32'h0042);
        // R10 DWord offsets
        acc(0, 5'h14, 2'd2, 32'h0);
        chk(10, "pointer at 0x14", rsp_rdata, 32'd18);
        acc(1, 5'h12, 2'd1, 32'd3);
        chk(10, "word access illegal", 32'(rsp_err), 32'h1);
        acc(0, 5'h00, 2'd2, 32'h0);
        chk(10, "station dword read", rsp_rdata, 32'hA1B2_0000);
        acc(1, 5'h08, 2'd2, 32'hDEAD_BEEF);
        acc(0, 5'h08, 2'd2, 32'h0);
        chk(10, "station dword write", rsp_rdata, 32'hDEAD_BEEF);

        // R4 busy length and R7 mode kept across soft reset
        acc(0, 5'h18, 2'd2, 32'h0);
        begin
            int n = 0;
            while (srst_busy) begin n++; @(negedge clk); end
            chk(4, "busy cycles", n, SRST);
        end
        acc(1, 5'h14, 2'd2, 32'd18);
        acc(0, 5'h1C, 2'd2, 32'h0);
        chk(7, "mode kept after soft reset", rsp_rdata, 32'h0080);

        // R7 hard reset returns to Word mode and clears banks
        hard_reset();
        acc(1, 5'h12, 2'd1, 32'd18);
        chk(7, "word write legal again", 32'(rsp_err), 32'h0);
        acc(0, 5'h16, 2'd1, 32'h0);
        chk(7, "mode flag after hard reset", rsp_rdata, 32'h0);
        acc(0, 5'h02, 2'd1, 32'h0);
        chk(7, "station cleared", rsp_rdata, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule